// File: doc/BRIEF.md
# Flash Write-Protection Region Decoder

This block guards program and erase commands for a 32 MiB serial flash array. It holds a four-bit protect-size code in the status register and an origin select bit in the configuration register. From these two fields it works out a contiguous protected region, anchored at either the highest or the lowest address. Every program or erase that arrives with the write-enable latch set is either granted or blocked, depending on whether its address range touches that region.

Commands arrive one per cycle as an opcode with an address and a 16-bit write payload. Byte 0 of the payload is the new status byte and byte 1 is the new configuration byte. Results appear as one-cycle pulses on the cycle after the command. The origin bit is one-time programmable: it can move the region from the top of the array to the bottom, and nothing moves it back. Reset models power-up.

Top module: `prot_region_guard`

## Requirements
- R1: After reset the write-enable latch, the protect code and the origin bit are all 0, so a status read (05h) returns 00h and a configuration read (15h) returns 00h.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. The latch reads back as status bit 1.
- R3: Opcode 01h with the latch set loads the protect code from payload bits 5:2, reads back in status bits 5:2, and clears the latch. Without the latch set, 01h changes nothing.
- R4: The origin bit reads back as configuration bit 3 and is set by payload bit 11 of an accepted 01h. Once it is 1, no write clears it.
- R5: Protect code 0 protects nothing. Code n from 1 to 9 protects 2^(n-1) blocks of 64 KiB. Codes 10 to 15 protect the whole array.
- R6: With the origin bit 0 the region ends at the top address. With the origin bit 1 it starts at address 0.
- R7: A page program (02h) with the latch set pulses op_grant when its address is outside the region and op_block when it is inside. Either way the latch is cleared.
- R8: Erases cover 4 KiB (20h), 32 KiB (52h), 64 KiB (D8h) aligned around the address, or the whole array (C7h or 60h). An erase is blocked as a whole if any byte of its range lies in the region, so a chip erase is blocked whenever the code is not 0.
- R9: A program or erase issued while the latch is clear produces neither op_grant nor op_block.
- R10: A status or configuration read pulses rd_valid, with rd_data valid, one cycle after the command. Status bit 0 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Target byte address for program and erase |
| cmd_wdata | input | 16 | Register payload: [7:0] status, [15:8] configuration |
| rd_valid | output | 1 | Register read data valid |
| rd_data | output | 8 | Register read data |
| op_grant | output | 1 | Program or erase accepted |
| op_block | output | 1 | Program or erase rejected by protection |

## Verification
The hardest cases to reach are the ones that need a bottom-origin region of a given size. The origin bit can only be set once, and setting it takes a latch-enabled register write, so random traffic almost never reaches those cases with a useful protect code. The random phase therefore keeps payload bit 11 clear and covers the top-origin decode across all codes and erase sizes. A directed phase then sets the origin once and walks the region edges: the first and last protected block at code 1, a larger code, and a chip erase at codes 0 and 10 and above. Further writes then try to clear the origin bit.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_RDCR = 8'h15;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE4  = 8'h20;
  localparam logic [7:0] OP_BE32 = 8'h52;
  localparam logic [7:0] OP_BE64 = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'hC7;
  localparam logic [7:0] OP_CE_B = 8'h60;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_WREN, CLS_WRDI, CLS_WRSR, CLS_RDSR, CLS_RDCR, CLS_MOD
  } cmd_cls_t;

  localparam int STAT_BP_LSB = 2;
  localparam int STAT_WEL    = 1;
  localparam int CFG_ORIGIN  = 3;
endpackage

// File: rtl/prot_cmd_decode.sv
module prot_cmd_decode
  import prot_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic [7:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output cmd_cls_t          cls,
  output logic [ADDR_W-1:0] rng_lo,
  output logic [ADDR_W-1:0] rng_hi
);
  function automatic logic [ADDR_W-1:0] low_mask(input int lg);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < lg);
    return m;
  endfunction

  logic [ADDR_W-1:0] mask;

  always_comb begin
    cls  = CLS_NONE;
    mask = '0;
    unique case (op)
      OP_WREN: cls = CLS_WREN;
      OP_WRDI: cls = CLS_WRDI;
      OP_WRSR: cls = CLS_WRSR;
      OP_RDSR: cls = CLS_RDSR;
      OP_RDCR: cls = CLS_RDCR;
      OP_PP:   cls = CLS_MOD;
      OP_SE4:  begin cls = CLS_MOD; mask = low_mask(12); end
      OP_BE32: begin cls = CLS_MOD; mask = low_mask(15); end
      OP_BE64: begin cls = CLS_MOD; mask = low_mask(16); end
      OP_CE_A, OP_CE_B: begin cls = CLS_MOD; mask = '1; end
      default: cls = CLS_NONE;
    endcase
    rng_lo = addr & ~mask;
    rng_hi = addr | mask;
  end
endmodule

// File: rtl/prot_region_match.sv
module prot_region_match #(
  parameter int ADDR_W   = 25,
  parameter int BLK_LOG2 = 16
) (
  input  logic [3:0]        bp,
  input  logic              origin_bottom,
  input  logic [ADDR_W-1:0] rng_lo,
  input  logic [ADDR_W-1:0] rng_hi,
  output logic              hit
);
  localparam int NBLK_LOG2 = ADDR_W - BLK_LOG2;
  localparam logic [ADDR_W:0] MEM_BYTES = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] BLK_BYTES =
    {{(ADDR_W-BLK_LOG2){1'b0}}, 1'b1, {BLK_LOG2{1'b0}}};

  function automatic logic [ADDR_W:0] region_bytes(input logic [3:0] code);
    if (code == 4'd0) return '0;
    if (int'(code) - 1 >= NBLK_LOG2) return MEM_BYTES;
    return BLK_BYTES << (code - 4'd1);
  endfunction

  logic [ADDR_W:0] size;
  always_comb begin
    size = region_bytes(bp);
    if (size == '0)
      hit = 1'b0;
    else if (origin_bottom)
      hit = {1'b0, rng_lo} < size;
    else
      hit = {1'b0, rng_hi} >= (MEM_BYTES - size);
  end
endmodule

// File: rtl/prot_reg_file.sv
module prot_reg_file (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       wr_fire,
  input  logic [3:0] bp_new,
  input  logic       origin_new,
  output logic       wel_q,
  output logic [3:0] bp_q,
  output logic       origin_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      bp_q     <= 4'd0;
      origin_q <= 1'b0;
    end else begin
      if (wel_set)      wel_q <= 1'b1;
      else if (wel_clr) wel_q <= 1'b0;
      if (wr_fire) begin
        bp_q     <= bp_new;
        origin_q <= origin_q | origin_new;
      end
    end
  end
endmodule

// File: rtl/prot_region_guard.sv
module prot_region_guard
  import prot_pkg::*;
#(
  parameter int ADDR_W   = 25,
  parameter int BLK_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              op_grant,
  output logic              op_block
);
  cmd_cls_t          cls;
  logic [ADDR_W-1:0] rng_lo, rng_hi;
  logic              hit;
  logic              wel_q, origin_q;
  logic [3:0]        bp_q;

  logic wel_set_w, wel_clr_w, wrsr_fire_w, mod_try_w, rd_req_w;

  prot_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .op(cmd_op), .addr(cmd_addr), .cls(cls), .rng_lo(rng_lo), .rng_hi(rng_hi)
  );

  prot_region_match #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_match (
    .bp(bp_q), .origin_bottom(origin_q), .rng_lo(rng_lo), .rng_hi(rng_hi),
    .hit(hit)
  );

  assign wel_set_w   = cmd_valid && (cls == CLS_WREN);
  assign wrsr_fire_w = cmd_valid && (cls == CLS_WRSR) && wel_q;
  assign mod_try_w   = cmd_valid && (cls == CLS_MOD) && wel_q;
  assign wel_clr_w   = (cmd_valid && (cls == CLS_WRDI)) || wrsr_fire_w || mod_try_w;
  assign rd_req_w    = cmd_valid && ((cls == CLS_RDSR) || (cls == CLS_RDCR));

  prot_reg_file u_regs (
    .clk(clk), .rst_n(rst_n),
    .wel_set(wel_set_w), .wel_clr(wel_clr_w), .wr_fire(wrsr_fire_w),
    .bp_new(cmd_wdata[STAT_BP_LSB +: 4]),
    .origin_new(cmd_wdata[8 + CFG_ORIGIN]),
    .wel_q(wel_q), .bp_q(bp_q), .origin_q(origin_q)
  );

  logic [7:0] stat_byte, cfg_byte;
  always_comb begin
    stat_byte = 8'h00;
    stat_byte[STAT_BP_LSB +: 4] = bp_q;
    stat_byte[STAT_WEL] = wel_q;
    cfg_byte = 8'h00;
    cfg_byte[CFG_ORIGIN] = origin_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      op_grant <= 1'b0;
      op_block <= 1'b0;
    end else begin
      rd_valid <= rd_req_w;
      if (rd_req_w) rd_data <= (cls == CLS_RDSR) ? stat_byte : cfg_byte;
      op_grant <= mod_try_w && !hit;
      op_block <= mod_try_w && hit;
    end
  end
endmodule

// File: rtl/prot_region_guard_chk.sv
module prot_region_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_grant,
  input logic       op_block,
  input logic       rd_valid,
  input logic       wel_q,
  input logic       origin_q,
  input logic [3:0] bp_q,
  input logic       wrsr_fire_w,
  input logic       mod_try_w,
  input logic       rd_req_w,
  input logic       cmd_valid,
  input logic [7:0] cmd_op
);
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_block));
  a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (op_grant || op_block) |-> !wel_q);
  a_r4_origin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    origin_q |=> origin_q);
  a_r3_bp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsr_fire_w |=> $stable(bp_q));
  a_r9_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wel_q && !mod_try_w) |=> !(op_grant || op_block));
  a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_w |=> rd_valid);
  a_r8_chip_erase_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_try_w && (cmd_op == 8'hC7 || cmd_op == 8'h60) && bp_q != 4'd0) |=> op_block);
endmodule

bind prot_region_guard prot_region_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_grant(op_grant), .op_block(op_block),
  .rd_valid(rd_valid), .wel_q(wel_q), .origin_q(origin_q), .bp_q(bp_q),
  .wrsr_fire_w(wrsr_fire_w), .mod_try_w(mod_try_w), .rd_req_w(rd_req_w),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/prot_region_guard_tb_top.sv
module prot_region_guard_tb_top;
  localparam int AW = 25;
  localparam int NBLK = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = 16'h0000;
  logic rd_valid, op_grant, op_block;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  bit m_wel = 0;
  bit m_org = 0;
  int m_bp  = 0;

  always #10 clk = ~clk;

  prot_region_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .op_grant(op_grant), .op_block(op_block)
  );

  function automatic int blocks_for(int code);
    if (code == 0) return 0;
    if (code >= 10) return NBLK;
    return 1 << (code - 1);
  endfunction

  function automatic int erase_kb(logic [7:0] op);
    case (op)
      8'h02: return 0;
      8'h20: return 4;
      8'h52: return 32;
      8'hD8: return 64;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_mod(logic [7:0] op);
    return op == 8'h02 || op == 8'h20 || op == 8'h52 || op == 8'hD8 ||
           op == 8'hC7 || op == 8'h60;
  endfunction

  function automatic bit covered(logic [7:0] op, logic [AW-1:0] a, int code, bit bottom);
    int n, lo_blk, hi_blk;
    n = blocks_for(code);
    if (erase_kb(op) < 0) begin lo_blk = 0; hi_blk = NBLK - 1; end
    else begin lo_blk = int'(a >> 16); hi_blk = lo_blk; end
    if (n == 0) return 0;
    if (bottom) return lo_blk < n;
    return hi_blk >= NBLK - n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] op, logic [AW-1:0] a, logic [15:0] wd, string req);
    bit e_rv, e_g, e_b;
    logic [7:0] e_rd;
    e_rv = 0; e_g = 0; e_b = 0; e_rd = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    if (op == 8'h05) begin e_rv = 1; e_rd = 8'((m_bp << 2) | (int'(m_wel) << 1)); end
    else if (op == 8'h15) begin e_rv = 1; e_rd = m_org ? 8'h08 : 8'h00; end
    else if (op == 8'h06) m_wel = 1;
    else if (op == 8'h04) m_wel = 0;
    else if (op == 8'h01 && m_wel) begin
      m_bp = int'(wd[5:2]); m_org = m_org | wd[11]; m_wel = 0;
    end else if (is_mod(op) && m_wel) begin
      e_b = covered(op, a, m_bp, m_org); e_g = !e_b; m_wel = 0;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rd_valid == e_rv, req, int'(rd_valid), int'(e_rv));
    if (e_rv) check(rd_data == e_rd, req, int'(rd_data), int'(e_rd));
    check(op_grant == e_g && op_block == e_b, req,
          int'({op_grant, op_block}), int'({e_g, e_b}));
  endtask

  task automatic set_bp(int code, bit org);
    send(8'h06, '0, 16'h0, "R2");
    send(8'h01, '0, {4'h0, org, 3'b0, 2'b0, 4'(code), 2'b0}, "R3");
  endtask

  task automatic wr_mod(logic [7:0] op, logic [AW-1:0] a, string req);
    send(8'h06, '0, 16'h0, "R2");
    send(op, a, 16'h0, req);
  endtask

  initial begin
    #(20ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [11];
    ops = '{8'h06, 8'h04, 8'h01, 8'h05, 8'h15, 8'h02, 8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60};
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    send(8'h05, '0, 16'h0, "R1");
    send(8'h15, '0, 16'h0, "R1");
    // R2: latch set/clear seen in status bit 1
    send(8'h06, '0, 16'h0, "R2");
    send(8'h05, '0, 16'h0, "R2");
    send(8'h04, '0, 16'h0, "R2");
    send(8'h05, '0, 16'h0, "R2");
    // R3: write without latch ignored
    send(8'h01, '0, 16'h003C, "R3");
    send(8'h05, '0, 16'h0, "R3");
    // R9: program without latch does nothing
    send(8'h02, 25'h1FFFFFF, 16'h0, "R9");
    // random phase, top origin only
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [7:0] op;
      k = ($urandom % 3 == 0) ? 0 : int'($urandom % 11);
      op = ops[k];
      send(op, AW'($urandom), 16'($urandom) & 16'hF7FF,
           is_mod(op) ? "R7" : (op == 8'h01 ? "R3" : "R10"));
    end
    // R5/R6: top origin, code 1, boundary blocks
    set_bp(1, 0);
    send(8'h05, '0, 16'h0, "R3");
    wr_mod(8'h02, 25'h1FF0000, "R6");
    wr_mod(8'h02, 25'h1FEFFFF, "R6");
    wr_mod(8'h20, 25'h1FEF000, "R8");
    send(8'h05, '0, 16'h0, "R7");
    // R5: code 4 -> 8 blocks
    set_bp(4, 0);
    wr_mod(8'hD8, 25'h1F80000, "R5");
    wr_mod(8'hD8, 25'h1F7FFFF, "R5");
    // R8: chip erase
    set_bp(0, 0);
    wr_mod(8'hC7, '0, "R8");
    set_bp(10, 0);
    wr_mod(8'h60, '0, "R8");
    wr_mod(8'h02, 25'h0000000, "R5");
    set_bp(15, 0);
    wr_mod(8'h02, 25'h0000000, "R5");
    // R4: set bottom origin, then try to clear
    set_bp(1, 1);
    send(8'h15, '0, 16'h0, "R4");
    set_bp(1, 0);
    send(8'h15, '0, 16'h0, "R4");
    // R6: bottom origin boundaries
    wr_mod(8'h02, 25'h000FFFF, "R6");
    wr_mod(8'h02, 25'h0010000, "R6");
    wr_mod(8'h02, 25'h1FFFFFF, "R6");
    set_bp(6, 0);
    wr_mod(8'h52, 25'h01F8000, "R8");
    wr_mod(8'h52, 25'h0200000, "R8");
    wr_mod(8'hC7, '0, "R8");
    // random phase with bottom origin
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [7:0] op;
      k = ($urandom % 3 == 0) ? 0 : int'($urandom % 11);
      op = ops[k];
      send(op, AW'($urandom), 16'($urandom), is_mod(op) ? "R7" : "R4");
    end
    send(8'h15, '0, 16'h0, "R4");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule